// File: doc/BRIEF.md
# Bounded-Gap Relocating Address Checker

This block sits on the address path between a processor and physical memory. It gives the running task one contiguous physical region. Inside that region the heap grows upward from the bottom and the stack grows downward from the top. The unused space between them is a forbidden gap, bounded by a low limit and a high limit. Any access that falls strictly inside the gap is flagged as a fault. All other accesses pass through.

In the same cycle, and in parallel with the limit check, the incoming address is relocated. A per-task base is added to it, and any carry out of the most significant bit is dropped. The relocated address, the fault flag and a memory strobe are registered together. The strobe is held low on a faulting access, so a gap access never reaches memory. How the fault is reported back to the processor is left to the surrounding logic.

Three configuration registers hold the base, the low limit and the high limit. They are loaded through a simple write port with a 2-bit select. A write changes only requests sampled on later clock edges.

Top module: `gap_reloc_mmu`

## Requirements
- R1: During and after synchronous active-low reset, `out_valid`, `out_fault`, `mem_strobe` and `out_addr` are 0, and the base, low limit and high limit are all 0, so no address faults until the registers are written.
- R2: For a request sampled with `req_valid` high at a clock edge, the outputs that follow that edge give `out_valid` = 1 and `out_addr` = `req_addr` + base.
- R3: The relocation sum keeps only its low `ADDR_W` bits; the carry out of the top bit is discarded, so the sum wraps modulo 2^`ADDR_W`.
- R4: A valid request whose address is strictly greater than the low limit and strictly less than the high limit (unsigned) gives `out_fault` = 1 one cycle later.
- R5: A valid request whose address equals the low limit or the high limit gives `out_fault` = 0.
- R6: `mem_strobe` is 1 exactly when the registered request was valid and did not fault; it is never 1 together with `out_fault`.
- R7: A configuration write with `cfg_we` = 1 updates the selected register at that clock edge. A request sampled at the same edge still uses the old value; requests sampled at later edges use the new one. Select encoding: 0 = base, 1 = low limit, 2 = high limit.
- R8: A write with select value 3 changes no register.
- R9: A request with `req_valid` = 0 gives `out_valid` = 0, `out_fault` = 0 and `mem_strobe` = 0, whatever its address.
- R10: When the low limit is greater than or equal to the high limit, the gap is empty and no address faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming access request is present |
| req_addr | input | ADDR_W | Task-relative address of the access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 low limit, 2 high limit, 3 none |
| cfg_wdata | input | ADDR_W | Configuration write data |
| out_valid | output | 1 | Registered copy of the request valid |
| out_addr | output | ADDR_W | Relocated physical address |
| out_fault | output | 1 | Access fell strictly inside the gap |
| mem_strobe | output | 1 | Access strobe to memory, low on fault |

## Verification
The bench targets addresses one step inside and exactly on each limit. A design that used inclusive compares would fault on a limit address, and one that used the wrong inequality would let the edge of the gap through. It relocates with a base near the top of the space so that the sum wraps; a design that saturated or kept the carry would give the wrong physical address. It writes a register in the same cycle as a request, and writes select value 3. A design that forwarded write data into the in-flight translation, or decoded the spare select onto a real register, would give a translation or fault decision that differs from the model. Inverted windows (low limit at or above high limit) and invalid requests carrying gap addresses check that no spurious fault or strobe appears.

// File: rtl/gap_mmu_pkg.sv
// Package: gap_mmu_pkg
// Shared select encoding and counts for the gap relocation checker.
// Assumes a 2-bit configuration select.
package gap_mmu_pkg;

    // Configuration register select codes
    typedef enum logic [1:0] {
        CFG_BASE  = 2'd0,
        CFG_LOW   = 2'd1,
        CFG_HIGH  = 2'd2,
        CFG_SPARE = 2'd3
    } cfg_sel_e;

    // Number of real configuration registers (codes below this value)
    localparam int unsigned NUM_CFG = 3;

endpackage

// File: rtl/gap_cfg_regs.sv
// Module: gap_cfg_regs
// Holds the relocation base and the two gap limits. A write lands at the
// clock edge on which cfg_we is high; the spare select code is dropped.
// Assumes synchronous active-low reset, all registers clear to zero.
module gap_cfg_regs
    import gap_mmu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] low_q,
    output logic [ADDR_W-1:0] high_q
);

    logic [ADDR_W-1:0] bank_q [NUM_CFG];

    // One storage register per real select code
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_bank
        // Load this register when its code is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (cfg_we && (cfg_sel == 2'(g))) begin
                bank_q[g] <= cfg_wdata;
            end
        end
    end

    assign base_q = bank_q[CFG_BASE];
    assign low_q  = bank_q[CFG_LOW];
    assign high_q = bank_q[CFG_HIGH];

    // R8: the spare code leaves every register unchanged
    p_spare_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == CFG_SPARE) |=>
            ($stable(base_q) && $stable(low_q) && $stable(high_q)));

    // R7: a base write is visible on the next cycle
    p_base_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == CFG_BASE) |=> (base_q == $past(cfg_wdata)));

    // R7: a low-limit write leaves the base alone
    p_low_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == CFG_LOW) |=>
            (low_q == $past(cfg_wdata) && $stable(base_q)));

endmodule

// File: rtl/gap_window_check.sv
// Module: gap_window_check
// Flags an address lying strictly between the low and high limits
// (unsigned). An inverted or empty window never flags.
// Assumes all inputs are stable within the cycle; purely combinational.
module gap_window_check #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lim_low,
    input  logic [ADDR_W-1:0] lim_high,
    output logic              in_gap
);

    logic above_low;
    logic below_high;

    // Two independent strict comparisons, combined
    always_comb begin
        above_low  = (addr > lim_low);
        below_high = (addr < lim_high);
        in_gap     = above_low && below_high;
    end

endmodule

// File: rtl/gap_reloc_adder.sv
// Module: gap_reloc_adder
// Adds the task base to the address; the result keeps ADDR_W bits, so any
// carry out of the top bit is lost. Runs beside the window check.
// Assumes unsigned operands of equal width; purely combinational.
module gap_reloc_adder #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] phys
);

    // Modulo-2^ADDR_W sum
    always_comb begin
        phys = addr + base;
    end

endmodule

// File: rtl/gap_reloc_mmu.sv
// Module: gap_reloc_mmu
// Top level: checks each request against the gap limits and relocates it
// by the base, both in the same cycle, then registers the result. A
// faulting access drops the memory strobe. Writes affect later requests only.
// Assumes synchronous active-low reset and one request per cycle.
module gap_reloc_mmu
    import gap_mmu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fault,
    output logic              mem_strobe
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] low_q;
    logic [ADDR_W-1:0] high_q;
    logic              in_gap;
    logic [ADDR_W-1:0] phys;

    gap_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .low_q     (low_q),
        .high_q    (high_q)
    );

    gap_window_check #(.ADDR_W(ADDR_W)) u_win (
        .addr     (req_addr),
        .lim_low  (low_q),
        .lim_high (high_q),
        .in_gap   (in_gap)
    );

    gap_reloc_adder #(.ADDR_W(ADDR_W)) u_add (
        .addr (req_addr),
        .base (base_q),
        .phys (phys)
    );

    // Register the translation, fault and strobe together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            out_fault  <= 1'b0;
            mem_strobe <= 1'b0;
        end else begin
            out_valid  <= req_valid;
            out_addr   <= phys;
            out_fault  <= req_valid && in_gap;
            mem_strobe <= req_valid && !in_gap;
        end
    end

    // R6: strobe and fault are never high together
    p_strobe_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_strobe && out_fault));

    // R9: no strobe or fault without a valid request
    p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |=> (!mem_strobe && !out_fault && !out_valid));

    // R2/R3: output address is the wrapped sum of request and prior base
    p_reloc_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_addr == ADDR_W'($past(req_addr) + $past(base_q))));

    // R5: an address on either limit does not fault
    p_limit_edge_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr == low_q || req_addr == high_q)) |=> !out_fault);

    // R10: an inverted or empty window never faults
    p_empty_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q >= high_q) |=> !out_fault);

endmodule

// File: tb/gap_reloc_mmu_bench.sv
// Bench: behavioural reference model compared against the outputs each cycle.
module gap_reloc_mmu_bench;

    localparam int unsigned AW = 32;
    localparam time HALF = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          out_valid;
    logic [AW-1:0] out_addr;
    logic          out_fault;
    logic          mem_strobe;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    // Model state
    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] m_low = '0;
    logic [AW-1:0] m_high = '0;

    always #HALF clk = ~clk;

    gap_reloc_mmu #(.ADDR_W(AW)) u_gap_reloc_mmu (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .out_valid  (out_valid),
        .out_addr   (out_addr),
        .out_fault  (out_fault),
        .mem_strobe (mem_strobe)
    );

    task automatic check(input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, step model at posedge, compare at next negedge
    task automatic step(input string tag, input logic v, input logic [AW-1:0] a,
                        input logic we, input logic [1:0] sel, input logic [AW-1:0] wd);
        logic          e_valid;
        logic          e_fault;
        logic          e_strobe;
        logic [AW-1:0] e_addr;
        req_valid = v;
        req_addr  = a;
        cfg_we    = we;
        cfg_sel   = sel;
        cfg_wdata = wd;
        e_valid  = v;
        e_fault  = v && (a > m_low) && (a < m_high);
        e_strobe = v && !e_fault;
        e_addr   = a + m_base;
        @(posedge clk);
        if (we) begin
            case (sel)
                2'd0: m_base = wd;
                2'd1: m_low  = wd;
                2'd2: m_high = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        check(tag, "out_valid", AW'(out_valid), AW'(e_valid));
        check(tag, "out_fault", AW'(out_fault), AW'(e_fault));
        check(tag, "mem_strobe", AW'(mem_strobe), AW'(e_strobe));
        if (v) check(tag, "out_addr", out_addr, e_addr);
        req_valid = 1'b0;
        cfg_we    = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [1:0] sel, input logic [AW-1:0] wd);
        step(tag, 1'b0, '0, 1'b1, sel, wd);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        step(tag, 1'b1, a, 1'b0, 2'd0, '0);
    endtask

    initial begin
        logic [AW-1:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        check("R1", "out_valid", AW'(out_valid), '0);
        check("R1", "out_addr", out_addr, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_fault", AW'(out_fault), '0);
        check("R1", "mem_strobe", AW'(mem_strobe), '0);
        rd("R1", 32'h0000_0005);
        rd("R1", 32'h8000_0000);

        wr("R7", 2'd0, 32'h0000_1000);
        wr("R7", 2'd1, 32'h0000_4000);
        wr("R7", 2'd2, 32'h0000_C000);
        rd("R2", 32'h0000_0020);
        rd("R2", 32'h0001_2345);
        // R7: write in same cycle as request; request uses old base
        step("R7", 1'b1, 32'h0000_0020, 1'b1, 2'd0, 32'h0000_0200);
        rd("R7", 32'h0000_0020);
        // R4: strictly inside the gap
        rd("R4", 32'h0000_4001);
        rd("R4", 32'h0000_8000);
        rd("R4", 32'h0000_BFFF);
        // R5: on the limits
        rd("R5", 32'h0000_4000);
        rd("R5", 32'h0000_C000);
        rd("R6", 32'h0000_3FFF);
        rd("R6", 32'h0000_C001);
        // R7: limit write while a gap request is in flight
        step("R7", 1'b1, 32'h0000_5000, 1'b1, 2'd1, 32'h0000_6000);
        rd("R7", 32'h0000_5000);
        // R8: spare select writes nothing
        wr("R8", 2'd3, 32'h7777_0000);
        rd("R8", 32'h0000_0010);
        rd("R8", 32'h0000_6001);
        rd("R8", 32'h0000_6000);
        // R9: invalid requests with gap addresses
        step("R9", 1'b0, 32'h0000_8000, 1'b0, 2'd0, '0);
        step("R9", 1'b0, 32'h0000_7000, 1'b0, 2'd0, '0);
        // R3: wrapping relocation
        wr("R3", 2'd0, 32'hFFFF_F000);
        rd("R3", 32'h0000_2000);
        rd("R3", 32'hFFFF_FFFF);
        // R10: empty and inverted windows
        wr("R10", 2'd1, 32'h0000_9000);
        wr("R10", 2'd2, 32'h0000_9000);
        rd("R10", 32'h0000_9000);
        wr("R10", 2'd1, 32'h0000_A000);
        wr("R10", 2'd2, 32'h0000_3000);
        rd("R10", 32'h0000_5000);
        rd("R10", 32'h0000_A000);
        // R6: mixed patterns against the model
        wr("R6", 2'd1, 32'h1000_0000);
        wr("R6", 2'd2, 32'hF000_0000);
        wr("R6", 2'd0, 32'h8000_0001);
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R6", lfsr[3], lfsr, lfsr[9] & lfsr[4], lfsr[6:5], {lfsr[15:0], lfsr[31:16]});
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule